// File: doc/BRIEF.md
# Call, Return and Interrupt Stacking Sequencer

This block is the part of a small processor core that moves the program counter and the rest of the machine state between the register file and a byte-wide stack in memory. A request with a command code starts one of five sequences: subroutine call, subroutine return, software interrupt, unimplemented-opcode trap and return-from-interrupt. A sixth sequence, hardware interrupt entry, starts on its own. It starts only when an interrupt request is present at an instruction boundary, the interrupt mask is clear and no command is being requested in that cycle.

The stack grows downward and holds one byte per address. A 16-bit value is pushed low byte first and popped high byte first. Interrupt entry saves nine bytes: the return PC, Y, X, accumulator A, accumulator B and the condition code byte, pushed in that order. The condition code byte therefore ends at the lowest address. Interrupt entry then fetches a two-byte vector, with the high byte at the lower address. Each source has its own fixed vector. At the end of every sequence the block presents the new program counter, stack pointer and any restored registers for one cycle, together with their load strobes.

Top module: `stack_seq`

## Requirements
- R1: After reset, busy, done, mem_we, mem_re and every load strobe are low.
- R2: Subroutine call (command 0) writes the return PC low byte at SP-1, then its high byte at SP-2. It then presents the target as the new PC and SP-2 as the new SP, with done in the third cycle after acceptance.
- R3: Subroutine return (command 1) reads the PC high byte at SP, then the low byte at SP+1. It then presents that PC and SP+2, with done in the third cycle after acceptance.
- R4: Software interrupt (command 2) writes nine bytes at SP-1 down to SP-9: PC low, PC high, Y low, Y high, X low, X high, A, B, CC. It then reads the vector at 0xFFF6 (high) and 0xFFF7 (low). It presents that vector as PC, SP-9 as SP, and the stacked CC with bit 4 (I mask) set, with cc_load, and done arrives in the twelfth cycle.
- R5: Trap (command 3) stacks exactly like R4, but reads its vector from 0xFFF8 (high) and 0xFFF9 (low).
- R6: A hardware interrupt is accepted only in a cycle with insn_end high, irq high, i_mask low and req_valid low. Entry then behaves like R4, using the vector at 0xFFF2 and 0xFFF3.
- R7: While i_mask is high, an irq at an instruction boundary starts nothing: busy stays low and no memory access is made.
- R8: Return-from-interrupt (command 4) reads nine bytes from SP up to SP+8, in the order CC, B, A, X high, X low, Y high, Y low, PC high, PC low. It presents all of them with all load strobes and SP+9, with done in the tenth cycle. The values come only from the stack, not from the current register inputs.
- R9: Stack addresses wrap modulo 2^16 in both directions.
- R10: busy is high from the cycle after acceptance through the done cycle. done is a one-cycle pulse. Requests made while busy, and command codes 5 to 7, are ignored.
- R11: The memory port makes at most one access per cycle, never a read and a write together, and makes no access while idle. Read data is taken in the same cycle as mem_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request, sampled while idle |
| req_cmd | input | 3 | 0 call, 1 return, 2 software interrupt, 3 trap, 4 return-from-interrupt |
| req_target | input | 16 | Call target address |
| insn_end | input | 1 | Instruction boundary strobe |
| irq | input | 1 | Hardware interrupt request |
| i_mask | input | 1 | Current interrupt mask bit |
| pc_in | input | 16 | Return address to stack |
| sp_in | input | 16 | Current stack pointer |
| y_in | input | 16 | Current Y |
| x_in | input | 16 | Current X |
| a_in | input | 8 | Current accumulator A |
| b_in | input | 8 | Current accumulator B |
| cc_in | input | 8 | Current condition code byte |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of mem_re |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load strobe for pc_out |
| sp_out | output | 16 | New stack pointer |
| sp_load | output | 1 | Load strobe for sp_out |
| y_out | output | 16 | Restored Y |
| y_load | output | 1 | Load strobe for y_out |
| x_out | output | 16 | Restored X |
| x_load | output | 1 | Load strobe for x_out |
| a_out | output | 8 | Restored A |
| a_load | output | 1 | Load strobe for a_out |
| b_out | output | 8 | Restored B |
| b_load | output | 1 | Load strobe for b_out |
| cc_out | output | 8 | New condition code byte |
| cc_load | output | 1 | Load strobe for cc_out |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final load cycle |

## Verification
Most internal faults in this block surface on the memory port in the same cycle they occur. A wrong step counter or frame slot puts a wrong byte or address on the bus. A wrong stack pointer update breaks the one-per-cycle descending or ascending address run, and a wrong vector selection shows up in the two reads after the pushes. Faults in sequencing or completion show up as a done pulse in the wrong cycle of a fixed 3, 10 or 12 cycle sequence. The same class of fault can also give a wrong pc_out, sp_out or cc_out in the done cycle. Mistakes in interrupt acceptance show up as busy rising, or failing to rise, one cycle after the boundary strobe.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [15:0] VEC_IRQ  = 16'hFFF2,
  parameter logic [15:0] VEC_SWI  = 16'hFFF6,
  parameter logic [15:0] VEC_TRAP = 16'hFFF8,
  parameter int          I_BIT    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_cmd,
  input  logic [15:0] req_target,
  input  logic        insn_end,
  input  logic        irq,
  input  logic        i_mask,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] y_in,
  input  logic [15:0] x_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  b_in,
  input  logic [7:0]  cc_in,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_out,
  output logic        pc_load,
  output logic [15:0] sp_out,
  output logic        sp_load,
  output logic [15:0] y_out,
  output logic        y_load,
  output logic [15:0] x_out,
  output logic        x_load,
  output logic [7:0]  a_out,
  output logic        a_load,
  output logic [7:0]  b_out,
  output logic        b_load,
  output logic [7:0]  cc_out,
  output logic        cc_load,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_POP, S_VEC, S_FIN} st_t;
  localparam logic [2:0] K_CALL = 3'd0, K_RET = 3'd1, K_SWI = 3'd2,
                         K_TRAP = 3'd3, K_RTI = 3'd4, K_IRQ = 3'd5;
  localparam logic [7:0] I_MASK_SET = 8'd1 << I_BIT;

  st_t         st;
  logic [2:0]  kind;
  logic [3:0]  step;
  logic [15:0] sp, tgt;
  logic [71:0] frm;

  wire take_req = (st == S_IDLE) && req_valid && (req_cmd <= K_RTI);
  wire take_irq = (st == S_IDLE) && !req_valid && insn_end && irq && !i_mask;
  wire is_int   = (kind == K_SWI) || (kind == K_TRAP) || (kind == K_IRQ);
  wire short_op = (kind == K_CALL) || (kind == K_RET);
  wire [3:0]  last  = short_op ? 4'd1 : 4'd8;
  wire [3:0]  slot  = last - step;
  wire [15:0] sp_dn = sp - 16'd1;
  wire [15:0] sp_up = sp + 16'd1;
  wire [15:0] vec   = (kind == K_SWI) ? VEC_SWI : (kind == K_TRAP) ? VEC_TRAP : VEC_IRQ;
  wire        fin   = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      kind <= K_CALL;
      step <= '0;
      sp   <= '0;
      tgt  <= '0;
      frm  <= '0;
    end else begin
      case (st)
        S_IDLE: if (take_req || take_irq) begin
          kind <= take_req ? req_cmd : K_IRQ;
          sp   <= sp_in;
          tgt  <= req_target;
          frm  <= {cc_in, b_in, a_in, x_in, y_in, pc_in};
          step <= '0;
          st   <= (take_req && (req_cmd == K_RET || req_cmd == K_RTI)) ? S_POP : S_PUSH;
        end
        S_PUSH: begin
          sp <= sp_dn;
          if (step == last) begin
            step <= '0;
            st   <= is_int ? S_VEC : S_FIN;
          end else begin
            step <= step + 4'd1;
          end
        end
        S_POP: begin
          frm[{slot, 3'b000} +: 8] <= mem_rdata;
          sp <= sp_up;
          if (step == last) begin
            step <= '0;
            st   <= S_FIN;
          end else begin
            step <= step + 4'd1;
          end
        end
        S_VEC: begin
          if (step == 4'd0) begin
            frm[15:8] <= mem_rdata;
            step      <= 4'd1;
          end else begin
            frm[7:0] <= mem_rdata;
            step     <= '0;
            st       <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_we    = (st == S_PUSH);
  assign mem_re    = (st == S_POP) || (st == S_VEC);
  assign mem_addr  = (st == S_PUSH) ? sp_dn :
                     (st == S_POP)  ? sp :
                     (st == S_VEC)  ? vec + {15'd0, step[0]} : 16'd0;
  assign mem_wdata = (st == S_PUSH) ? frm[{step, 3'b000} +: 8] : 8'd0;

  assign busy    = (st != S_IDLE);
  assign done    = fin;
  assign pc_load = fin;
  assign sp_load = fin;
  assign pc_out  = (kind == K_CALL) ? tgt : frm[15:0];
  assign sp_out  = sp;
  assign y_out   = frm[31:16];
  assign x_out   = frm[47:32];
  assign a_out   = frm[55:48];
  assign b_out   = frm[63:56];
  assign cc_out  = (kind == K_RTI) ? frm[71:64] : (frm[71:64] | I_MASK_SET);
  assign y_load  = fin && (kind == K_RTI);
  assign x_load  = fin && (kind == K_RTI);
  assign a_load  = fin && (kind == K_RTI);
  assign b_load  = fin && (kind == K_RTI);
  assign cc_load = fin && ((kind == K_RTI) || is_int);
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        insn_end,
  input logic        i_mask,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic        pc_load,
  input logic        sp_load
);
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  a_r10_done_pulse:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r10_idle_after:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  a_r10_final_load:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (pc_load && sp_load));
  a_r11_port_excl:    assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  a_r11_idle_quiet:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_we && !mem_re));
  a_r9_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
                        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));
  a_r7_masked_idle:   assert property (@(posedge clk) disable iff (!rst_n)
                        (!busy && !req_valid && i_mask) |=> !busy);
  a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
                        (!busy && !req_valid && !insn_end) |=> !busy);
endmodule

bind stack_seq stack_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .insn_end(insn_end),
  .i_mask(i_mask), .busy(busy), .done(done), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .pc_load(pc_load), .sp_load(sp_load)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, insn_end = 1'b0, irq = 1'b0, i_mask = 1'b0;
  logic [2:0]  req_cmd = 3'd0;
  logic [15:0] req_target = '0, pc_in = '0, sp_in = '0, y_in = '0, x_in = '0;
  logic [7:0]  a_in = '0, b_in = '0, cc_in = '0;
  logic [15:0] mem_addr, pc_out, sp_out, y_out, x_out;
  logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, cc_out;
  logic mem_we, mem_re, pc_load, sp_load, y_load, x_load, a_load, b_load, cc_load, busy, done;

  logic [7:0]  bmem [0:255];
  logic [15:0] wa [0:31];
  logic [7:0]  wd [0:31];
  logic [15:0] ra [0:31];
  int wn = 0, rn = 0, total = 0, fails = 0;

  always #4 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_target(req_target), .insn_end(insn_end), .irq(irq), .i_mask(i_mask),
    .pc_in(pc_in), .sp_in(sp_in), .y_in(y_in), .x_in(x_in), .a_in(a_in),
    .b_in(b_in), .cc_in(cc_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .pc_load(pc_load), .sp_out(sp_out), .sp_load(sp_load), .y_out(y_out),
    .y_load(y_load), .x_out(x_out), .x_load(x_load), .a_out(a_out),
    .a_load(a_load), .b_out(b_out), .b_load(b_load), .cc_out(cc_out),
    .cc_load(cc_load), .busy(busy), .done(done)
  );

  assign mem_rdata = bmem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[7:0]] = mem_wdata;
      if (wn < 32) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
      wn++;
    end
    if (mem_re) begin
      if (rn < 32) ra[rn] = mem_addr;
      rn++;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic issue(input logic [2:0] cmd, input logic [15:0] sp, input logic [15:0] pc,
                       input logic [15:0] tgt, input bit poke, output int lat);
    @(negedge clk);
    wn = 0; rn = 0;
    req_valid = 1'b1; req_cmd = cmd; sp_in = sp; pc_in = pc; req_target = tgt;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      req_valid = 1'b0;
      if (poke && lat == 3) begin req_valid = 1'b1; req_cmd = 3'd0; end
    end while (!done && lat < 50);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 we/re", {mem_we, mem_re}, 0);
    chk("R1 loads", {pc_load, sp_load, y_load, x_load, a_load, b_load, cc_load}, 0);
  endtask

  task automatic t_call();
    int lat;
    issue(3'd0, 16'h0C80, 16'h1234, 16'h5678, 0, lat);
    chk("R2 latency", lat, 3); chk("R2 writes", wn, 2);
    chk("R2 w0", {wa[0], wd[0]}, {16'h0C7F, 8'h34});
    chk("R2 w1", {wa[1], wd[1]}, {16'h0C7E, 8'h12});
    chk("R2 pc", pc_out, 16'h5678); chk("R2 sp", sp_out, 16'h0C7E);
    chk("R2 no cc_load", cc_load, 0);
    @(negedge clk); chk("R10 idle after call", busy, 0);
  endtask

  task automatic t_ret();
    int lat;
    issue(3'd1, 16'h0C7E, 16'hFFFF, 16'h0, 0, lat);
    chk("R3 latency", lat, 3);
    chk("R3 read order", {ra[0], ra[1]}, {16'h0C7E, 16'h0C7F});
    chk("R3 pc", pc_out, 16'h1234); chk("R3 sp", sp_out, 16'h0C80);
  endtask

  task automatic stack_frame_chk(input string r);
    logic [7:0] exp [0:8];
    exp[0] = 8'h00; exp[1] = 8'h20; exp[2] = 8'h22; exp[3] = 8'h11; exp[4] = 8'h44;
    exp[5] = 8'h33; exp[6] = 8'h55; exp[7] = 8'h66; exp[8] = cc_in;
    chk({r, " writes"}, wn, 9);
    for (int k = 0; k < 9; k++)
      chk({r, " frame byte"}, {wa[k], wd[k]}, {16'h0C80 - 16'(k + 1), exp[k]});
  endtask

  task automatic set_regs();
    y_in = 16'h1122; x_in = 16'h3344; a_in = 8'h55; b_in = 8'h66; cc_in = 8'h00;
  endtask

  task automatic t_swi();
    int lat;
    set_regs();
    bmem[8'hF6] = 8'hAB; bmem[8'hF7] = 8'hCD;
    issue(3'd2, 16'h0C80, 16'h2000, 16'h0, 0, lat);
    chk("R4 latency", lat, 12);
    stack_frame_chk("R4");
    chk("R4 vector reads", {ra[0], ra[1]}, {16'hFFF6, 16'hFFF7});
    chk("R4 pc", pc_out, 16'hABCD); chk("R4 sp", sp_out, 16'h0C77);
    chk("R4 cc mask set", {cc_load, cc_out}, {1'b1, 8'h10});
  endtask

  task automatic t_rti();
    int lat;
    y_in = 16'hDEAD; x_in = 16'hBEEF; a_in = 8'h99; b_in = 8'h88; cc_in = 8'hFF;
    issue(3'd4, 16'h0C77, 16'hEEEE, 16'h0, 0, lat);
    chk("R8 latency", lat, 10);
    for (int k = 0; k < 9; k++) chk("R8 read order", ra[k], 16'h0C77 + 16'(k));
    chk("R8 y", y_out, 16'h1122); chk("R8 x", x_out, 16'h3344);
    chk("R8 a/b", {a_out, b_out}, {8'h55, 8'h66}); chk("R8 cc", cc_out, 8'h00);
    chk("R8 pc", pc_out, 16'h2000); chk("R8 sp", sp_out, 16'h0C80);
    chk("R8 loads", {pc_load, sp_load, y_load, x_load, a_load, b_load, cc_load}, 7'h7F);
  endtask

  task automatic t_trap_busy_ignore();
    int lat;
    set_regs();
    bmem[8'hF8] = 8'h9A; bmem[8'hF9] = 8'hBC;
    issue(3'd3, 16'h0C80, 16'h2000, 16'h0, 1, lat);
    chk("R5 latency", lat, 12);
    stack_frame_chk("R5");
    chk("R5 vector reads", {ra[0], ra[1]}, {16'hFFF8, 16'hFFF9});
    chk("R5 pc", pc_out, 16'h9ABC);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R10 request during busy ignored", {busy, 6'(wn)}, {1'b0, 6'd9});
    end
  endtask

  task automatic t_irq();
    int lat;
    set_regs(); cc_in = 8'h05;
    bmem[8'hF2] = 8'h7E; bmem[8'hF3] = 8'h01;
    @(negedge clk); wn = 0; rn = 0;
    irq = 1'b1; i_mask = 1'b1; insn_end = 1'b1;
    @(negedge clk); insn_end = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R7 masked irq ignored", {busy, 6'(wn), 6'(rn)}, 0); @(negedge clk);
    end
    i_mask = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R6 no boundary no entry", busy, 0);
    end
    pc_in = 16'h2000; sp_in = 16'h0C80; insn_end = 1'b1;
    lat = 0;
    do begin
      @(negedge clk); lat++; insn_end = 1'b0;
    end while (!done && lat < 50);
    irq = 1'b0;
    chk("R6 latency", lat, 12);
    stack_frame_chk("R6");
    chk("R6 vector reads", {ra[0], ra[1]}, {16'hFFF2, 16'hFFF3});
    chk("R6 pc", pc_out, 16'h7E01);
    chk("R6 cc mask set", {cc_load, cc_out}, {1'b1, 8'h15});
  endtask

  task automatic t_wrap();
    int lat;
    issue(3'd0, 16'h0001, 16'hA1B2, 16'h4000, 0, lat);
    chk("R9 wrap w0", {wa[0], wd[0]}, {16'h0000, 8'hB2});
    chk("R9 wrap w1", {wa[1], wd[1]}, {16'hFFFF, 8'hA1});
    chk("R9 wrap sp", sp_out, 16'hFFFF);
    issue(3'd1, 16'hFFFF, 16'h0, 16'h0, 0, lat);
    chk("R9 wrap reads", {ra[0], ra[1]}, {16'hFFFF, 16'h0000});
    chk("R9 wrap ret", {pc_out, sp_out}, {16'hA1B2, 16'h0001});
  endtask

  task automatic t_badcmd();
    @(negedge clk); wn = 0; rn = 0;
    req_valid = 1'b1; req_cmd = 3'd7;
    @(negedge clk); req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 unused command ignored", {busy, 6'(wn), 6'(rn)}, 0); @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call();
    t_ret();
    t_swi();
    t_rti();
    t_trap_busy_ignore();
    t_irq();
    t_wrap();
    t_badcmd();
    summary();
  end
endmodule